// File: doc/BRIEF.md
# Configurable Grid Processing Element

This block is one cell of a uniform two-dimensional compute array. It has a 16-bit neighbour port on each of its four sides (north, east, south, west). Each port carries a signed fixed-point value with 8 fractional bits. A configuration write loads three items: a 4-bit operation code, a 2-bit flow direction and a 16-bit stored argument. After the write, the cell runs exactly one of ten small operations on the values its neighbours present.

The flow direction decides the roles of the ports. The port facing away from the flow supplies the upstream (through) operand. The port one quarter-turn clockwise from the flow supplies the side operand. The result leaves only through the downstream port, the one the flow points at. The stored argument has a different meaning in each operation: it is a constant for the source, a weight for multiply-accumulate, a slope for the leaky rectifier and a reference for the gate.

Chains of these cells, each set to a different operation, build neurons, piecewise-linear function units and reductions. The cell registers its outputs, so each cell in a chain adds one pipeline stage.

Top module: `pe_cell`

## Requirements
- R1: While reset is high, and after it is released until the first configuration write, all four outputs are zero. The reset configuration is the block operation, direction 0 and argument 0.
- R2: A configuration write (cfg_we high) is captured on that clock edge and first governs the result produced at the following edge. Every output is registered, with one cycle from an input to the result it causes.
- R3: Direction codes are 0=north, 1=east, 2=south, 3=west, and they name the downstream port. The upstream operand comes from the opposite port, index (d+2) mod 4. The side operand comes from port (d+1) mod 4, with port indices N=0, E=1, S=2, W=3. The three ports other than downstream always output zero.
- R4: Op 0 (source) outputs the stored argument.
- R5: Op 1 (transfer) outputs the upstream operand unchanged.
- R6: Op 2 (multiply-accumulate) outputs upstream + round(side × argument). The rounding adds 128 to the 32-bit product and then shifts it right arithmetically by 8. The sum saturates to the range -32768..32767.
- R7: Op 3 (leaky rectifier) passes a non-negative upstream value unchanged. A negative upstream value becomes round(upstream × argument), with the same rounding and saturation as R6.
- R8: Op 4 outputs the signed maximum of the upstream and side operands. Op 5 outputs their signed minimum.
- R9: Op 6 (gate) outputs the upstream operand when the side operand equals the stored argument bit for bit, and outputs zero otherwise.
- R10: Op 7 (union) outputs the saturated signed sum of the upstream and side operands.
- R11: Op 8 (delay) outputs the upstream operand sampled one edge earlier than transfer would, which gives two cycles of latency. The delay stage samples the upstream port on every edge, whatever the operation.
- R12: Op 9 (block) and the unused codes 10 to 15 hold all outputs at zero, whatever the inputs and the argument.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 4 | Operation code to load |
| cfg_dir | input | 2 | Flow direction to load |
| cfg_arg | input | 16 | Stored argument to load |
| nb_n_i | input | 16 | Value from the north neighbour |
| nb_e_i | input | 16 | Value from the east neighbour |
| nb_s_i | input | 16 | Value from the south neighbour |
| nb_w_i | input | 16 | Value from the west neighbour |
| nb_n_o | output | 16 | Value to the north neighbour |
| nb_e_o | output | 16 | Value to the east neighbour |
| nb_s_o | output | 16 | Value to the south neighbour |
| nb_w_o | output | 16 | Value to the west neighbour |

## Verification
Faults in the configuration registers show up one edge after the write. A wrong operation or argument changes the downstream value, and a wrong direction moves the result onto another port or picks up the wrong operands. A stale delay register shows only under the delay operation, as a value one cycle off from the upstream history. A rounding or saturation error shows only for products with a half-LSB remainder or for sums beyond the range. For this reason the sequence includes such operands for each arithmetic operation, next to a long sweep of all sixteen codes in all four directions.

// File: rtl/pe_cell_pkg.sv
package pe_cell_pkg;
  localparam int NUM_PORTS = 4;
  localparam int OP_W      = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SRC = 4'd0,
    OP_TRS = 4'd1,
    OP_MAC = 4'd2,
    OP_PRL = 4'd3,
    OP_MAX = 4'd4,
    OP_MIN = 4'd5,
    OP_GAT = 4'd6,
    OP_UNI = 4'd7,
    OP_DEL = 4'd8,
    OP_BLK = 4'd9
  } pe_op_e;
endpackage

// File: rtl/pe_cfg_store.sv
module pe_cfg_store #(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int DIR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DIR_W-1:0]  dir_i,
  input  logic [DATA_W-1:0] arg_i,
  output logic [OP_W-1:0]   op_o,
  output logic [DIR_W-1:0]  dir_o,
  output logic [DATA_W-1:0] arg_o
);
  import pe_cell_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_o  <= OP_W'(OP_BLK);
      dir_o <= '0;
      arg_o <= '0;
    end else if (we_i) begin
      op_o  <= op_i;
      dir_o <= dir_i;
      arg_o <= arg_i;
    end
  end

  AST_CFG_TAKES: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (op_o == $past(op_i) && dir_o == $past(dir_i) && arg_o == $past(arg_i))); // R2
endmodule

// File: rtl/pe_port_route.sv
module pe_port_route #(
  parameter int DATA_W = 16,
  parameter int NPORT  = 4,
  parameter int DIR_W  = $clog2(NPORT)
) (
  input  logic [NPORT-1:0][DATA_W-1:0] in_i,
  input  logic [DIR_W-1:0]             dir_i,
  input  logic [DATA_W-1:0]            res_i,
  output logic [DATA_W-1:0]            up_o,
  output logic [DATA_W-1:0]            side_o,
  output logic [NPORT-1:0][DATA_W-1:0] out_o
);
  localparam logic [DIR_W-1:0] HALF_TURN    = DIR_W'(NPORT / 2);
  localparam logic [DIR_W-1:0] QUARTER_TURN = DIR_W'(1);

  logic [DIR_W-1:0] up_idx;
  logic [DIR_W-1:0] side_idx;

  assign up_idx   = dir_i + HALF_TURN;
  assign side_idx = dir_i + QUARTER_TURN;
  assign up_o     = in_i[up_idx];
  assign side_o   = in_i[side_idx];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign out_o[g] = (dir_i == DIR_W'(g)) ? res_i : '0;
  end
endmodule

// File: rtl/pe_alu.sv
module pe_alu #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  parameter int OP_W   = 4
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] arg_i,
  input  logic [DATA_W-1:0] up_i,
  input  logic [DATA_W-1:0] side_i,
  input  logic [DATA_W-1:0] del_i,
  output logic [DATA_W-1:0] res_o
);
  import pe_cell_pkg::*;

  localparam int     PROD_W = 2 * DATA_W;
  localparam int     WIDE_W = PROD_W + 1;
  localparam longint HI_L   = (longint'(1) << (DATA_W - 1)) - 1;
  localparam logic signed [WIDE_W-1:0] SAT_HI = WIDE_W'(HI_L);
  localparam logic signed [WIDE_W-1:0] SAT_LO = WIDE_W'(-HI_L - 1);
  localparam logic signed [PROD_W-1:0] HALF   = PROD_W'(longint'(1) << (FRAC_W - 1));

  function automatic logic [DATA_W-1:0] clamp(input logic signed [WIDE_W-1:0] v);
    if (v > SAT_HI) return SAT_HI[DATA_W-1:0];
    if (v < SAT_LO) return SAT_LO[DATA_W-1:0];
    return v[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] up_s, side_s, arg_s;
  logic signed [PROD_W-1:0] mac_prod, mac_rnd, prl_prod, prl_rnd;
  logic signed [WIDE_W-1:0] mac_sum, uni_sum;

  assign up_s     = up_i;
  assign side_s   = side_i;
  assign arg_s    = arg_i;
  assign mac_prod = PROD_W'(side_s) * PROD_W'(arg_s);
  assign mac_rnd  = (mac_prod + HALF) >>> FRAC_W;
  assign mac_sum  = WIDE_W'(mac_rnd) + WIDE_W'(up_s);
  assign prl_prod = PROD_W'(up_s) * PROD_W'(arg_s);
  assign prl_rnd  = (prl_prod + HALF) >>> FRAC_W;
  assign uni_sum  = WIDE_W'(up_s) + WIDE_W'(side_s);

  always_comb begin
    case (op_i)
      OP_SRC:  res_o = arg_i;
      OP_TRS:  res_o = up_i;
      OP_MAC:  res_o = clamp(mac_sum);
      OP_PRL:  res_o = up_s[DATA_W-1] ? clamp(WIDE_W'(prl_rnd)) : up_i;
      OP_MAX:  res_o = (up_s > side_s) ? up_i : side_i;
      OP_MIN:  res_o = (up_s < side_s) ? up_i : side_i;
      OP_GAT:  res_o = (side_i == arg_i) ? up_i : '0;
      OP_UNI:  res_o = clamp(uni_sum);
      OP_DEL:  res_o = del_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/pe_cell.sv
module pe_cell #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_op,
  input  logic [1:0]        cfg_dir,
  input  logic [DATA_W-1:0] cfg_arg,
  input  logic [DATA_W-1:0] nb_n_i,
  input  logic [DATA_W-1:0] nb_e_i,
  input  logic [DATA_W-1:0] nb_s_i,
  input  logic [DATA_W-1:0] nb_w_i,
  output logic [DATA_W-1:0] nb_n_o,
  output logic [DATA_W-1:0] nb_e_o,
  output logic [DATA_W-1:0] nb_s_o,
  output logic [DATA_W-1:0] nb_w_o
);
  import pe_cell_pkg::*;

  localparam int NPORT = NUM_PORTS;
  localparam int DIR_W = $clog2(NPORT);

  logic [OP_W-1:0]             op_q;
  logic [DIR_W-1:0]            dir_q;
  logic [DATA_W-1:0]           arg_q;
  logic [NPORT-1:0][DATA_W-1:0] in_w, out_d, out_q;
  logic [DATA_W-1:0]           up_w, side_w, res_w, del_q;

  pe_cfg_store #(.DATA_W(DATA_W), .OP_W(OP_W), .DIR_W(DIR_W)) u_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we), .op_i(cfg_op), .dir_i(cfg_dir),
    .arg_i(cfg_arg), .op_o(op_q), .dir_o(dir_q), .arg_o(arg_q)
  );

  assign in_w = {nb_w_i, nb_s_i, nb_e_i, nb_n_i};

  pe_port_route #(.DATA_W(DATA_W), .NPORT(NPORT), .DIR_W(DIR_W)) u_route (
    .in_i(in_w), .dir_i(dir_q), .res_i(res_w),
    .up_o(up_w), .side_o(side_w), .out_o(out_d)
  );

  pe_alu #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .OP_W(OP_W)) u_alu (
    .op_i(op_q), .arg_i(arg_q), .up_i(up_w), .side_i(side_w),
    .del_i(del_q), .res_o(res_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      del_q <= '0;
    end else begin
      out_q <= out_d;
      del_q <= up_w;
    end
  end

  assign nb_n_o = out_q[0];
  assign nb_e_o = out_q[1];
  assign nb_s_o = out_q[2];
  assign nb_w_o = out_q[3];

  // cycles since reset, saturating; qualifies two-deep history checks
  logic [1:0] live_cnt;
  always_ff @(posedge clk) begin
    if (rst) live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  AST_SINGLE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({|out_q[3], |out_q[2], |out_q[1], |out_q[0]})); // R3
  AST_BLOCK_SILENT: assert property (@(posedge clk) disable iff (rst)
    (op_q >= 4'd9) |=> (out_q == '0)); // R12
  AST_SOURCE_EMITS: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_SRC) |=> (out_q[$past(dir_q)] == $past(arg_q))); // R4
  AST_GATE_SHUT: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_GAT && side_w != arg_q) |=> (out_q == '0)); // R9
  AST_DELAY_TWO: assert property (@(posedge clk) disable iff (rst)
    (live_cnt == 2'd3 && op_q == OP_DEL && $stable(dir_q))
      |=> (out_q[$past(dir_q)] == $past(up_w, 2))); // R11
endmodule

// File: tb/pe_cell_tb_top.sv
module pe_cell_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_op = '0;
  logic [1:0]  cfg_dir = '0;
  logic [15:0] cfg_arg = '0;
  logic [15:0] vin [4];
  logic [15:0] nb_n_o, nb_e_o, nb_s_o, nb_w_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_op = 9, m_dir = 0, m_arg = 0, m_del = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  pe_cell dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_dir(cfg_dir),
    .cfg_arg(cfg_arg), .nb_n_i(vin[0]), .nb_e_i(vin[1]), .nb_s_i(vin[2]),
    .nb_w_i(vin[3]), .nb_n_o(nb_n_o), .nb_e_o(nb_e_o), .nb_s_o(nb_s_o),
    .nb_w_o(nb_w_o)
  );

  function automatic int s16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int rnd(input int v);
    return (v + 128) >>> 8;
  endfunction

  function automatic int ref_res(input int op, input int arg, input int p,
                                 input int s, input int d);
    case (op)
      0: return arg;
      1: return p;
      2: return sat(p + rnd(s * arg));
      3: return (p >= 0) ? p : sat(rnd(p * arg));
      4: return (p > s) ? p : s;
      5: return (p < s) ? p : s;
      6: return (s == arg) ? p : 0;
      7: return sat(p + s);
      8: return d;
      default: return 0;
    endcase
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4, 5: return "R8";
      6: return "R9";
      7: return "R10";
      8: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [15:0] lcg();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[27:12];
  endfunction

  task automatic compare(input logic [63:0] exp_v, input string tag);
    logic [63:0] got;
    got = {nb_w_o, nb_s_o, nb_e_o, nb_n_o};
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp_v);
    end
  endtask

  // drive one cycle at the falling edge, advance the model, compare after the edge
  task automatic step(input logic we, input int op, input int dir, input int arg,
                      input logic [15:0] n, input logic [15:0] e,
                      input logic [15:0] s, input logic [15:0] w, input string tag);
    logic [3:0][15:0] exp_v;
    int p, sd;
    cfg_we = we; cfg_op = 4'(op); cfg_dir = 2'(dir); cfg_arg = 16'(arg);
    vin[0] = n; vin[1] = e; vin[2] = s; vin[3] = w;
    p  = s16(vin[(m_dir + 2) % 4]);
    sd = s16(vin[(m_dir + 1) % 4]);
    exp_v = '0;
    exp_v[m_dir] = 16'(ref_res(m_op, m_arg, p, sd, m_del));
    m_del = p;
    if (we) begin
      m_op = op; m_dir = dir; m_arg = s16(16'(arg));
    end
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    compare(exp_v, tag);
  endtask

  task automatic cfg(input int op, input int dir, input int arg, input string tag);
    step(1'b1, op, dir, arg, 16'h0, 16'h0, 16'h0, 16'h0, tag);
  endtask

  task automatic drv(input logic [15:0] n, input logic [15:0] e,
                     input logic [15:0] s, input logic [15:0] w, input string tag);
    step(1'b0, 0, 0, 0, n, e, s, w, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) vin[i] = 16'h5A5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(64'h0, "R1 during reset");
    rst = 1'b0;
    drv(16'h1111, 16'h2222, 16'h3333, 16'h4444, "R1 after reset");

    // R2: a write governs the next edge, not the one that captures it
    cfg(0, 1, 16'h0180, "R2 old block config still in force");
    drv(16'h0, 16'h0, 16'h0, 16'h0, "R4 source on east");
    step(1'b1, 1, 1, 0, 16'h0, 16'h0, 16'h0, 16'h1234, "R2 source still active at write edge");
    drv(16'h0, 16'h0, 16'h0, 16'h1234, "R5 transfer west to east");

    // R3: each flow direction
    for (int d = 0; d < 4; d++) begin
      cfg(1, d, 0, "R3 direction write");
      drv(16'h0A01, 16'h0B02, 16'h0C03, 16'h0D04, "R3 upstream routing");
      cfg(7, d, 0, "R3 direction write");
      drv(16'h0001, 16'h0010, 16'h0100, 16'h1000, "R3 side routing");
    end

    // R6 multiply-accumulate, east flow: upstream=west, side=south
    cfg(2, 1, 16'h0200, "R6 config");
    drv(16'h0, 16'h0, 16'h0180, 16'h0100, "R6 basic");
    drv(16'h0, 16'h0, 16'h7000, 16'h7000, "R6 positive saturation");
    drv(16'h0, 16'h0, 16'h8000, 16'h8000, "R6 negative saturation");
    cfg(2, 1, 16'h0080, "R6 config half weight");
    drv(16'h0, 16'h0, 16'h0001, 16'h0, "R6 round half up");
    drv(16'h0, 16'h0, 16'hFFFF, 16'h0, "R6 round negative half");

    cfg(3, 1, 16'h0019, "R7 config");
    drv(16'h0, 16'h0, 16'h0, 16'hFE00, "R7 negative scaled");
    drv(16'h0, 16'h0, 16'h0, 16'h0300, "R7 positive passes");
    cfg(3, 1, 16'h7FFF, "R7 config large slope");
    drv(16'h0, 16'h0, 16'h0, 16'h8000, "R7 saturation");

    cfg(4, 1, 0, "R8 max config");
    drv(16'h0, 16'h0, 16'h0100, 16'hFF00, "R8 max signed");
    cfg(5, 1, 0, "R8 min config");
    drv(16'h0, 16'h0, 16'hFF80, 16'h0200, "R8 min signed");

    cfg(6, 1, 16'h02FF, "R9 config");
    drv(16'h0, 16'h0, 16'h02FF, 16'h0555, "R9 gate open");
    drv(16'h0, 16'h0, 16'h0300, 16'h0555, "R9 gate closed");

    cfg(7, 1, 0, "R10 config");
    drv(16'h0, 16'h0, 16'h0123, 16'h0, "R10 single source");
    drv(16'h0, 16'h0, 16'h0200, 16'h7F00, "R10 saturation");

    cfg(8, 1, 0, "R11 config");
    drv(16'h0, 16'h0, 16'h0, 16'h0011, "R11 delay");
    drv(16'h0, 16'h0, 16'h0, 16'h0022, "R11 delay");
    drv(16'h0, 16'h0, 16'h0, 16'h0033, "R11 delay");

    cfg(9, 1, 16'hAAAA, "R12 block config");
    drv(16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA, "R12 block silent");
    cfg(12, 2, 16'hAAAA, "R12 unused code config");
    drv(16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA, "R12 unused code silent");

    // sweep of all codes and directions against the model
    for (int op = 0; op < 16; op++) begin
      for (int d = 0; d < 4; d++) begin
        logic [15:0] a;
        a = lcg();
        cfg(op, d, a, op_tag(op));
        for (int k = 0; k < 8; k++) begin
          logic [15:0] v [4];
          for (int j = 0; j < 4; j++) v[j] = lcg();
          if (op == 6 && k[0]) v[(d + 1) % 4] = a;
          if (op == 7 && k[0]) v[(d + 1) % 4] = 16'h0;
          drv(v[0], v[1], v[2], v[3], op_tag(op));
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule